// File: doc/BRIEF.md
# Retention-Binned Page Allocator

This block hands out physical memory pages while keeping refresh as slow as possible. Each page is assigned to a retention class when it is loaded. Classes are numbered so that class 0 holds the pages with the longest measured retention time, and the numbers rise as retention falls. Pages that test too weak for use are marked excluded during loading. They are never placed on any list, so they can never be handed out. Each class keeps its own free list, built as a linked list in on-chip storage with a head pointer and a tail pointer.

An allocation request takes the head page from the lowest-numbered class that has a free page, so long-retention pages are always used first. A returned page goes back to the tail of its own class list. Each class also counts its allocated pages. The block derives one refresh period from these counts: the lower retention boundary of the highest-numbered class that holds at least one allocated page. Every page is still refreshed at this period. The period only has to be safe for pages that are in use. Class boundaries and the page table are written through load ports before normal operation starts.

Top module: `ret_bin_alloc`

## Requirements
- R1: After reset there is no grant and no out-of-memory flag, the refresh period is 0, and every class list is empty, so a first request is answered with out-of-memory.
- R2: A page load records the page's class. If the page is not excluded, it is appended to the tail of that class's list. An excluded page is never granted.
- R3: A request sampled at a clock edge is answered on the outputs after that edge. The grant carries the head page of the lowest-numbered class whose list is not empty. Class 0 holds the longest retention.
- R4: Within one class, pages are granted in the order they joined the list, whether they joined by load or by release.
- R5: When every list is empty, a request raises the out-of-memory flag for one cycle, with no grant. No list and no count changes.
- R6: A release appends the page to the tail of the class it was loaded into, and lowers that class's allocated count by one.
- R7: The refresh period is the boundary of the highest-numbered class with a nonzero allocated count. It is the class 0 boundary when no page is allocated. It is registered, so it follows a grant or release one cycle after the grant flag appears.
- R8: A boundary write stores a period value for one class. It is reflected in the refresh period two cycles later.
- R9: A request and a release in the same cycle both take effect. The grant is chosen from the lists as they stood before the release. If the chosen class held one page and the release returns a page to that same class, the released page becomes that class's only entry.
- R10: The grant flag and the out-of-memory flag are never high together. Neither is raised unless a request was sampled on the edge before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bnd_we | input | 1 | Class boundary write strobe |
| bnd_cls | input | $clog2(NUM_CLS) | Class whose boundary is written |
| bnd_val | input | PER_W | Lower retention boundary of the class, used as refresh period |
| ld_valid | input | 1 | Page table load strobe |
| ld_page | input | $clog2(NUM_PAGES) | Page being loaded |
| ld_cls | input | $clog2(NUM_CLS) | Retention class of the loaded page |
| ld_excl | input | 1 | Page is excluded from allocation |
| alloc_req | input | 1 | Allocation request |
| alloc_gnt | output | 1 | Allocation granted (one cycle) |
| alloc_page | output | $clog2(NUM_PAGES) | Granted page, valid with alloc_gnt |
| alloc_oom | output | 1 | Request refused, no free page (one cycle) |
| rel_valid | input | 1 | Page release strobe |
| rel_page | input | $clog2(NUM_PAGES) | Page being released |
| refresh_period | output | PER_W | Current single refresh period |

## Verification
A grant and a release can land in the same cycle. When they touch the same class, the pop at the head and the append at the tail meet on one linked list and on one counter. The bench provokes this in three ways. It pairs a request with a release across every allocated page. It drains a class to a single entry and then requests while releasing into that class. It requests and releases together while every list is empty. The bench keeps its own per-class queues and counts. From those it judges the granted page, the out-of-memory flag and the refresh period that follows. The grant must come from the lists before the release, and the released page must be the next one granted from its class.

// File: rtl/ret_bin_alloc_pkg.sv
package ret_bin_alloc_pkg;

  // Source of the single tail-append performed by the free lists each cycle
  typedef enum logic [1:0] {
    APP_NONE = 2'd0,
    APP_LOAD = 2'd1,
    APP_REL  = 2'd2
  } app_src_e;

endpackage

// File: rtl/rba_freelist.sv
module rba_freelist
  import ret_bin_alloc_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int NUM_CLS   = 4,
  localparam int PGW = $clog2(NUM_PAGES),
  localparam int CLW = $clog2(NUM_CLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  input  logic [PGW-1:0]     ld_page,
  input  logic [CLW-1:0]     ld_cls,
  input  logic               ld_excl,
  input  logic               rel_valid,
  input  logic [PGW-1:0]     rel_page,
  input  logic               pop_valid,
  input  logic [CLW-1:0]     pop_cls,
  output logic [NUM_CLS-1:0] nonempty,
  output logic [PGW-1:0]     head_page,
  output logic [CLW-1:0]     rel_cls
);

  logic [CLW-1:0] cls_q  [NUM_PAGES];
  logic [CLW-1:0] cls_d  [NUM_PAGES];
  logic           excl_q [NUM_PAGES];
  logic           excl_d [NUM_PAGES];
  logic [PGW-1:0] nxt_q  [NUM_PAGES];
  logic [PGW-1:0] nxt_d  [NUM_PAGES];
  logic [PGW-1:0] head_q [NUM_CLS];
  logic [PGW-1:0] head_d [NUM_CLS];
  logic [PGW-1:0] tail_q [NUM_CLS];
  logic [PGW-1:0] tail_d [NUM_CLS];
  logic [NUM_CLS-1:0] ne_q, ne_d;

  app_src_e       app_src;
  logic [PGW-1:0] app_page;
  logic [CLW-1:0] app_cls;

  assign nonempty  = ne_q;
  assign head_page = head_q[pop_cls];
  assign rel_cls   = cls_q[rel_page];

  always_comb begin
    if (rel_valid)                 app_src = APP_REL;
    else if (ld_valid && !ld_excl) app_src = APP_LOAD;
    else                           app_src = APP_NONE;
    app_page = rel_valid ? rel_page : ld_page;
    app_cls  = rel_valid ? cls_q[rel_page] : ld_cls;
  end

  always_comb begin
    cls_d  = cls_q;
    excl_d = excl_q;
    nxt_d  = nxt_q;
    head_d = head_q;
    tail_d = tail_q;
    ne_d   = ne_q;
    if (ld_valid && !rel_valid) begin
      cls_d[ld_page]  = ld_cls;
      excl_d[ld_page] = ld_excl;
    end
    // pop first, from the state before this cycle's append
    if (pop_valid) begin
      if (head_q[pop_cls] == tail_q[pop_cls]) ne_d[pop_cls] = 1'b0;
      else                                    head_d[pop_cls] = nxt_q[head_q[pop_cls]];
    end
    if (app_src != APP_NONE) begin
      if (!ne_d[app_cls]) begin
        head_d[app_cls] = app_page;
        tail_d[app_cls] = app_page;
        ne_d[app_cls]   = 1'b1;
      end else begin
        nxt_d[tail_q[app_cls]] = app_page;
        tail_d[app_cls]        = app_page;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ne_q <= '0;
      for (int p = 0; p < NUM_PAGES; p++) begin
        cls_q[p]  <= '0;
        excl_q[p] <= 1'b0;
        nxt_q[p]  <= '0;
      end
      for (int c = 0; c < NUM_CLS; c++) begin
        head_q[c] <= '0;
        tail_q[c] <= '0;
      end
    end else begin
      ne_q   <= ne_d;
      cls_q  <= cls_d;
      excl_q <= excl_d;
      nxt_q  <= nxt_d;
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  // R2: a page marked excluded never sits at the head of a list being popped
  assert_no_excl_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> !excl_q[head_q[pop_cls]]);

  // R3: popping is only requested from a class whose list holds a page
  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> ne_q[pop_cls]);

endmodule

// File: rtl/rba_cls_pick.sv
module rba_cls_pick #(
  parameter int NUM_CLS = 4,
  localparam int CLW = $clog2(NUM_CLS)
) (
  input  logic [NUM_CLS-1:0] nonempty,
  output logic               any,
  output logic [CLW-1:0]     sel
);

  // lowest-numbered (longest-retention) class with a free page wins
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int c = NUM_CLS - 1; c >= 0; c--) begin
      if (nonempty[c]) begin
        any = 1'b1;
        sel = CLW'(c);
      end
    end
  end

endmodule

// File: rtl/rba_period.sv
module rba_period #(
  parameter int NUM_PAGES = 16,
  parameter int NUM_CLS   = 4,
  parameter int PER_W     = 16,
  localparam int CLW = $clog2(NUM_CLS),
  localparam int CW  = $clog2(NUM_PAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bnd_we,
  input  logic [CLW-1:0]   bnd_cls,
  input  logic [PER_W-1:0] bnd_val,
  input  logic             inc_valid,
  input  logic [CLW-1:0]   inc_cls,
  input  logic             dec_valid,
  input  logic [CLW-1:0]   dec_cls,
  output logic [PER_W-1:0] period
);

  logic [PER_W-1:0] bnd_q [NUM_CLS];
  logic [CW-1:0]    cnt_q [NUM_CLS];
  logic [PER_W-1:0] per_d, per_q;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    logic          up, dn, cnt_en, bnd_en;
    logic [CW-1:0] cnt_r, cnt_n;
    logic [PER_W-1:0] bnd_r;

    assign up     = inc_valid && (inc_cls == CLW'(g));
    assign dn     = dec_valid && (dec_cls == CLW'(g));
    assign cnt_en = up ^ dn;
    assign bnd_en = bnd_we && (bnd_cls == CLW'(g));

    always_comb cnt_n = up ? cnt_r + CW'(1) : cnt_r - CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_r <= '0;
        bnd_r <= '0;
      end else begin
        if (cnt_en) cnt_r <= cnt_n;
        if (bnd_en) bnd_r <= bnd_val;
      end
    end

    assign cnt_q[g] = cnt_r;
    assign bnd_q[g] = bnd_r;

    // R6: a release never hits a class with nothing allocated
    assert_cnt_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && !up) |-> (cnt_r != '0));

    // R6: count never exceeds the number of pages
    assert_cnt_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_r <= CW'(NUM_PAGES));
  end

  always_comb begin
    per_d = bnd_q[0];
    for (int c = 0; c < NUM_CLS; c++) begin
      if (cnt_q[c] != '0) per_d = bnd_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= '0;
    else        per_q <= per_d;
  end

  assign period = per_q;

  // R7: an occupied weakest class always sets the period
  assert_weakest_sets_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[NUM_CLS-1] != '0) |=> (period == $past(bnd_q[NUM_CLS-1])));

endmodule

// File: rtl/ret_bin_alloc.sv
module ret_bin_alloc #(
  parameter int NUM_PAGES = 16,
  parameter int NUM_CLS   = 4,
  parameter int PER_W     = 16,
  localparam int PGW = $clog2(NUM_PAGES),
  localparam int CLW = $clog2(NUM_CLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bnd_we,
  input  logic [CLW-1:0]   bnd_cls,
  input  logic [PER_W-1:0] bnd_val,
  input  logic             ld_valid,
  input  logic [PGW-1:0]   ld_page,
  input  logic [CLW-1:0]   ld_cls,
  input  logic             ld_excl,
  input  logic             alloc_req,
  output logic             alloc_gnt,
  output logic [PGW-1:0]   alloc_page,
  output logic             alloc_oom,
  input  logic             rel_valid,
  input  logic [PGW-1:0]   rel_page,
  output logic [PER_W-1:0] refresh_period
);

  logic [NUM_CLS-1:0] nonempty;
  logic               any_free;
  logic [CLW-1:0]     pick_cls;
  logic [PGW-1:0]     head_page;
  logic [CLW-1:0]     rel_cls;
  logic               pop;

  logic           gnt_q, gnt_d;
  logic           oom_q, oom_d;
  logic [PGW-1:0] page_q, page_d;

  assign pop = alloc_req && any_free;

  rba_cls_pick #(.NUM_CLS(NUM_CLS)) u_pick (
    .nonempty (nonempty),
    .any      (any_free),
    .sel      (pick_cls)
  );

  rba_freelist #(.NUM_PAGES(NUM_PAGES), .NUM_CLS(NUM_CLS)) u_lists (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_page   (ld_page),
    .ld_cls    (ld_cls),
    .ld_excl   (ld_excl),
    .rel_valid (rel_valid),
    .rel_page  (rel_page),
    .pop_valid (pop),
    .pop_cls   (pick_cls),
    .nonempty  (nonempty),
    .head_page (head_page),
    .rel_cls   (rel_cls)
  );

  rba_period #(.NUM_PAGES(NUM_PAGES), .NUM_CLS(NUM_CLS), .PER_W(PER_W)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .bnd_we    (bnd_we),
    .bnd_cls   (bnd_cls),
    .bnd_val   (bnd_val),
    .inc_valid (pop),
    .inc_cls   (pick_cls),
    .dec_valid (rel_valid),
    .dec_cls   (rel_cls),
    .period    (refresh_period)
  );

  always_comb begin
    gnt_d  = pop;
    oom_d  = alloc_req && !any_free;
    page_d = pop ? head_page : page_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= 1'b0;
      oom_q  <= 1'b0;
      page_q <= '0;
    end else begin
      gnt_q  <= gnt_d;
      oom_q  <= oom_d;
      page_q <= page_d;
    end
  end

  assign alloc_gnt  = gnt_q;
  assign alloc_oom  = oom_q;
  assign alloc_page = page_q;

  // R10: grant and refusal are exclusive
  assert_gnt_oom_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_gnt && alloc_oom));

  // R10: no answer without a sampled request
  assert_answer_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt || alloc_oom) |-> $past(alloc_req));

  // R5: refusal only when every list was empty
  assert_oom_all_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_oom |-> ($past(nonempty) == '0));

  // R3: a request with some free page is always granted
  assert_req_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && (nonempty != '0)) |=> alloc_gnt);

endmodule

// File: tb/ret_bin_alloc_tb.sv
module ret_bin_alloc_tb;

  localparam int NP  = 16;
  localparam int NC  = 4;
  localparam int PW  = 16;
  localparam int PGW = $clog2(NP);
  localparam int CLW = $clog2(NC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bnd_we = 1'b0;
  logic [CLW-1:0] bnd_cls = '0;
  logic [PW-1:0]  bnd_val = '0;
  logic ld_valid = 1'b0;
  logic [PGW-1:0] ld_page = '0;
  logic [CLW-1:0] ld_cls = '0;
  logic ld_excl = 1'b0;
  logic alloc_req = 1'b0;
  logic alloc_gnt;
  logic [PGW-1:0] alloc_page;
  logic alloc_oom;
  logic rel_valid = 1'b0;
  logic [PGW-1:0] rel_page = '0;
  logic [PW-1:0] refresh_period;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model
  int q_m    [NC][NP];
  int qh_m   [NC];
  int qt_m   [NC];
  int cnt_m  [NC];
  int bnd_m  [NC];
  int cls_m  [NP];
  bit excl_m [NP];
  bit held_m [NP];

  always #4 clk = ~clk;

  ret_bin_alloc #(.NUM_PAGES(NP), .NUM_CLS(NC), .PER_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bnd_we(bnd_we), .bnd_cls(bnd_cls), .bnd_val(bnd_val),
    .ld_valid(ld_valid), .ld_page(ld_page), .ld_cls(ld_cls), .ld_excl(ld_excl),
    .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_page(alloc_page),
    .alloc_oom(alloc_oom),
    .rel_valid(rel_valid), .rel_page(rel_page),
    .refresh_period(refresh_period)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_period();
    int r = bnd_m[0];
    for (int c = 0; c < NC; c++) if (cnt_m[c] != 0) r = bnd_m[c];
    return r;
  endfunction

  task automatic push_m(input int c, input int p);
    q_m[c][qt_m[c] % NP] = p;
    qt_m[c]++;
  endtask

  task automatic set_bnd(input int c, input int v);
    @(negedge clk);
    bnd_we = 1'b1; bnd_cls = CLW'(c); bnd_val = PW'(v);
    bnd_m[c] = v;
    @(negedge clk);
    bnd_we = 1'b0;
  endtask

  task automatic load_page(input int p, input int c, input bit x);
    @(negedge clk);
    ld_valid = 1'b1; ld_page = PGW'(p); ld_cls = CLW'(c); ld_excl = x;
    cls_m[p] = c; excl_m[p] = x;
    if (!x) push_m(c, p);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // one request and/or release, then one idle cycle for the period
  task automatic op(input bit a, input bit r, input int rp, input string req);
    bit eg = 0, eo = 0;
    int ep = 0;
    @(negedge clk);
    alloc_req = a; rel_valid = r; rel_page = PGW'(rp);
    if (a) begin
      for (int c = NC - 1; c >= 0; c--) if (qh_m[c] != qt_m[c]) ep = c + 100;
      if (ep >= 100) begin
        ep = ep - 100;
        eg = 1;
        cnt_m[ep]++;
        ep = q_m[ep][qh_m[ep] % NP];
        qh_m[cls_m[ep]]++;
        held_m[ep] = 1;
      end else begin
        eo = 1;
      end
    end
    if (r) begin
      push_m(cls_m[rp], rp);
      cnt_m[cls_m[rp]]--;
      held_m[rp] = 0;
    end
    @(negedge clk);
    alloc_req = 1'b0; rel_valid = 1'b0;
    check({req, " R10 grant flag"}, int'(alloc_gnt), int'(eg));
    check({req, " R5 oom flag"}, int'(alloc_oom), int'(eo));
    if (eg) begin
      check({req, " R3 R4 granted page"}, int'(alloc_page), ep);
      check({req, " R2 not excluded"}, int'(excl_m[alloc_page]), 0);
    end
    @(negedge clk);
    check({req, " R7 period"}, int'(refresh_period), exp_period());
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int p0, q0;
    for (int c = 0; c < NC; c++) begin
      qh_m[c] = 0; qt_m[c] = 0; cnt_m[c] = 0; bnd_m[c] = 0;
    end
    for (int p = 0; p < NP; p++) begin
      cls_m[p] = 0; excl_m[p] = 0; held_m[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 grant after reset", int'(alloc_gnt), 0);
    check("R1 oom after reset", int'(alloc_oom), 0);
    check("R1 period after reset", int'(refresh_period), 0);
    op(1, 0, 0, "R1 first request");

    // R8 boundaries, strongest class first
    set_bnd(0, 45300);
    set_bnd(1, 40600);
    set_bnd(2, 35900);
    set_bnd(3, 7700);
    @(negedge clk);
    check("R8 boundary reaches period", int'(refresh_period), 45300);
    set_bnd(0, 45000);
    @(negedge clk);
    check("R8 boundary rewrite", int'(refresh_period), 45000);

    // R2 page table, pages 5 and 10 excluded
    for (int p = 0; p < NP; p++)
      load_page(p, (p ^ (p >> 2)) & 3, (p == 5) || (p == 10));

    // R3 R4 drain every free page, then R5 refusals
    for (int k = 0; k < NP + 2; k++) op(1, 0, 0, "R3 drain");

    // R6 release every held page, highest number first
    for (int p = NP - 1; p >= 0; p--) if (held_m[p]) op(0, 1, p, "R6 release");

    // R4 regrant order follows release order
    for (int k = 0; k < 7; k++) op(1, 0, 0, "R4 regrant");

    // R9 request paired with release of each held page
    for (int p = 0; p < NP; p++) if (held_m[p]) op(1, 1, p, "R9 paired");

    // drain again
    for (int k = 0; k < NP; k++) op(1, 0, 0, "R5 drain2");

    // R9 single-entry class meets a release into the same class
    p0 = -1; q0 = -1;
    for (int p = 0; p < NP; p++) if (held_m[p] && p0 < 0) p0 = p;
    for (int p = 0; p < NP; p++)
      if (held_m[p] && p != p0 && cls_m[p] == cls_m[p0] && q0 < 0) q0 = p;
    op(0, 1, p0, "R6 single release");
    op(1, 1, q0, "R9 one-entry swap");
    op(1, 0, 0, "R9 released page next");
    // R9 all empty: refusal, released page still joins
    op(1, 1, p0, "R9 empty paired");
    op(1, 0, 0, "R9 empty then grant");
    op(0, 0, 0, "R10 idle");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule